// File: doc/BRIEF.md
# Predicated Vector Saturating Scalar Add/Subtract Unit

This unit applies one scalar to every lane of a vector with saturating arithmetic. The vector is 128 bits wide and splits into byte, halfword or word lanes. The scalar is cut down to the lane width and then added to, or subtracted from, each lane, as signed or unsigned values. Each lane result is first formed exactly at a wider precision. It is then clamped to the lane's representable range.

A per-byte write mask merges the result into the previous destination vector byte by byte. A byte whose mask bit is clear keeps its old value. The unit also keeps a sticky cumulative-saturation flag. A lane that clamps sets this flag only when the mask bit of that lane's lowest byte is set. The merged vector and the flag update appear one clock after the input strobe.

Top module: `vsat_scalar_unit`

## Requirements
- R1: `elem_size` 0 selects 16 byte lanes, 1 selects 8 halfword lanes and 2 selects 4 word lanes. Lane e occupies bits [e*W +: W] of the vector, where W is 8, 16 or 32.
- R2: The low W bits of `scalar` are the second operand for every lane.
- R3: `sub_sel`=0 adds and `sub_sel`=1 subtracts (lane minus scalar). The result is exact unless it leaves the lane range, and in that case it is clamped to the nearest limit.
- R4: `uns_sel`=0 uses the two's-complement limits -2^(W-1) and 2^(W-1)-1. `uns_sel`=1 uses the limits 0 and 2^W-1.
- R5: Byte i of `dst_new` takes the result byte when `byte_mask[i]` is 1. Otherwise it takes byte i of `dst_old`.
- R6: `sat_flag` is set only by a lane that clamped while the mask bit of its lowest byte (bit e*W/8) is 1. A clamping lane whose lowest-byte mask bit is 0 leaves the flag unchanged.
- R7: `sat_flag` is sticky and only `clr_flag` clears it. If a qualifying clamp arrives in the same cycle as the clear, the flag ends up set.
- R8: `dst_new` and the flag update are registered one cycle after `in_valid`, and `out_valid` is asserted for that cycle. When `in_valid` is low, `dst_new` holds its value.
- R9: `elem_size`=3 is a no-op. `dst_new` receives `dst_old` unchanged, the flag is not set, and `out_valid` still follows `in_valid`.
- R10: While `rst_n` is low, `out_valid`, `dst_new` and `sat_flag` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clr_flag | input | 1 | Clears the sticky saturation flag |
| in_valid | input | 1 | Operation strobe |
| vec_n | input | 128 | Vector operand |
| scalar | input | 32 | Scalar operand |
| dst_old | input | 128 | Previous destination vector |
| byte_mask | input | 16 | Per-byte write mask |
| elem_size | input | 2 | Lane size code |
| uns_sel | input | 1 | 1 selects unsigned, 0 selects signed |
| sub_sel | input | 1 | 1 selects subtract, 0 selects add |
| out_valid | output | 1 | Result valid |
| dst_new | output | 128 | Merged result vector |
| sat_flag | output | 1 | Sticky cumulative-saturation flag |

## Verification
The flag clear and a qualifying saturation can land on the same clock edge. The bench provokes this by holding `clr_flag` high while it issues a signed add that overflows lane 0 with every mask bit set. It then checks that the flag reads 1. The bench also pairs a clear with a clamp whose lowest-byte mask bit is 0, and expects the flag to read 0. In that same case the written upper byte must still carry the clamped value.

// File: rtl/vsat_pkg.sv
package vsat_pkg;
   typedef enum logic [1:0] {
      SZ_BYTE = 2'd0,
      SZ_HALF = 2'd1,
      SZ_WORD = 2'd2,
      SZ_NONE = 2'd3
   } lane_size_e;

   localparam int unsigned NUM_SIZES = 3;
endpackage

// File: rtl/vsat_elem.sv
module vsat_elem #(
   parameter int unsigned LW = 8
) (
   input  logic [LW-1:0] a_i,
   input  logic [LW-1:0] b_i,
   input  logic          uns_i,
   input  logic          sub_i,
   output logic [LW-1:0] res_o,
   output logic          sat_o
);
   localparam int unsigned XW = LW + 2;

   logic signed [XW-1:0] ax, bx, exact, hi, lo;

   always_comb begin
      ax    = uns_i ? $signed({2'b00, a_i}) : $signed({{2{a_i[LW-1]}}, a_i});
      bx    = uns_i ? $signed({2'b00, b_i}) : $signed({{2{b_i[LW-1]}}, b_i});
      exact = sub_i ? (ax - bx) : (ax + bx);
      hi    = uns_i ? $signed({2'b00, {LW{1'b1}}}) : $signed({3'b000, {(LW-1){1'b1}}});
      lo    = uns_i ? '0 : $signed({3'b111, {(LW-1){1'b0}}});
      if (exact > hi) begin
         res_o = hi[LW-1:0];
         sat_o = 1'b1;
      end else if (exact < lo) begin
         res_o = lo[LW-1:0];
         sat_o = 1'b1;
      end else begin
         res_o = exact[LW-1:0];
         sat_o = 1'b0;
      end
   end
endmodule

// File: rtl/vsat_bank.sv
module vsat_bank #(
   parameter int unsigned VEC_W = 128,
   parameter int unsigned SC_W  = 32,
   parameter int unsigned LW    = 8
) (
   input  logic [VEC_W-1:0]   vec_i,
   input  logic [SC_W-1:0]    scal_i,
   input  logic [VEC_W/8-1:0] mask_i,
   input  logic               uns_i,
   input  logic               sub_i,
   output logic [VEC_W-1:0]   res_o,
   output logic               qual_o
);
   localparam int unsigned NE = VEC_W / LW;
   localparam int unsigned EB = LW / 8;

   logic [NE-1:0] sat_v;
   logic [NE-1:0] qual_v;

   for (genvar e = 0; e < NE; e++) begin : g_elem
      vsat_elem #(.LW(LW)) u_elem (
         .a_i   (vec_i[e*LW +: LW]),
         .b_i   (scal_i[LW-1:0]),
         .uns_i (uns_i),
         .sub_i (sub_i),
         .res_o (res_o[e*LW +: LW]),
         .sat_o (sat_v[e])
      );
      assign qual_v[e] = sat_v[e] & mask_i[e*EB];
   end

   assign qual_o = |qual_v;
endmodule

// File: rtl/vsat_scalar_unit.sv
module vsat_scalar_unit
   import vsat_pkg::*;
#(
   parameter int unsigned VEC_W = 128,
   parameter int unsigned SC_W  = 32
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               clr_flag,
   input  logic               in_valid,
   input  logic [VEC_W-1:0]   vec_n,
   input  logic [SC_W-1:0]    scalar,
   input  logic [VEC_W-1:0]   dst_old,
   input  logic [VEC_W/8-1:0] byte_mask,
   input  logic [1:0]         elem_size,
   input  logic               uns_sel,
   input  logic               sub_sel,
   output logic               out_valid,
   output logic [VEC_W-1:0]   dst_new,
   output logic               sat_flag
);
   localparam int unsigned NB     = VEC_W / 8;
   localparam int unsigned MAX_LW = 8 << (NUM_SIZES - 1);

   if ((VEC_W % MAX_LW) != 0) begin : g_bad_vec
      $error("VEC_W must be a multiple of the widest lane");
   end
   if (SC_W < MAX_LW) begin : g_bad_sc
      $error("SC_W must cover the widest lane");
   end

   logic [VEC_W-1:0] bank_res [NUM_SIZES];
   logic [NUM_SIZES-1:0] bank_q;

   for (genvar g = 0; g < NUM_SIZES; g++) begin : g_bank
      vsat_bank #(.VEC_W(VEC_W), .SC_W(SC_W), .LW(8 << g)) u_bank (
         .vec_i  (vec_n),
         .scal_i (scalar),
         .mask_i (byte_mask),
         .uns_i  (uns_sel),
         .sub_i  (sub_sel),
         .res_o  (bank_res[g]),
         .qual_o (bank_q[g])
      );
   end

   logic [VEC_W-1:0] sel_res;
   logic             sel_q;
   logic             legal;
   logic [VEC_W-1:0] merged;

   always_comb begin
      legal   = 1'b1;
      sel_res = bank_res[0];
      sel_q   = bank_q[0];
      unique case (lane_size_e'(elem_size))
         SZ_BYTE: begin sel_res = bank_res[0]; sel_q = bank_q[0]; end
         SZ_HALF: begin sel_res = bank_res[1]; sel_q = bank_q[1]; end
         SZ_WORD: begin sel_res = bank_res[2]; sel_q = bank_q[2]; end
         default: begin sel_res = dst_old; sel_q = 1'b0; legal = 1'b0; end
      endcase
   end

   for (genvar i = 0; i < NB; i++) begin : g_merge
      assign merged[i*8 +: 8] = (legal && byte_mask[i]) ? sel_res[i*8 +: 8]
                                                        : dst_old[i*8 +: 8];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         dst_new   <= '0;
         sat_flag  <= 1'b0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) dst_new <= merged;
         sat_flag  <= (sat_flag & ~clr_flag) | (in_valid & sel_q);
      end
   end
endmodule

// File: rtl/vsat_chk.sv
module vsat_chk #(
   parameter int unsigned VEC_W = 128,
   parameter int unsigned SC_W  = 32
) (
   input logic               clk,
   input logic               rst_n,
   input logic               clr_flag,
   input logic               in_valid,
   input logic [VEC_W-1:0]   vec_n,
   input logic [SC_W-1:0]    scalar,
   input logic [VEC_W-1:0]   dst_old,
   input logic [VEC_W/8-1:0] byte_mask,
   input logic [1:0]         elem_size,
   input logic               out_valid,
   input logic [VEC_W-1:0]   dst_new,
   input logic               sat_flag
);
   AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid); // R8
   AST_VALID_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid); // R8
   AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> $stable(dst_new)); // R8
   AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sat_flag) |-> $past(clr_flag)); // R7
   AST_MASK_NONE: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && byte_mask == '0) |=> dst_new == $past(dst_old)); // R5
   AST_ILLEGAL_NOP: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && elem_size == 2'd3 && !clr_flag) |=>
         (dst_new == $past(dst_old) && sat_flag == $past(sat_flag))); // R9
   AST_ZERO_SCALAR: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && scalar == '0 && elem_size != 2'd3 && (&byte_mask)) |=>
         dst_new == $past(vec_n)); // R2
   AST_NO_QUAL_NO_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (byte_mask == '0 || !in_valid) |=> !$rose(sat_flag)); // R6
endmodule

bind vsat_scalar_unit vsat_chk #(.VEC_W(VEC_W), .SC_W(SC_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .clr_flag  (clr_flag),
   .in_valid  (in_valid),
   .vec_n     (vec_n),
   .scalar    (scalar),
   .dst_old   (dst_old),
   .byte_mask (byte_mask),
   .elem_size (elem_size),
   .out_valid (out_valid),
   .dst_new   (dst_new),
   .sat_flag  (sat_flag)
);

// File: tb/tb_vsat_scalar_unit.sv
module tb_vsat_scalar_unit;
   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         clr_flag = 1'b0;
   logic         in_valid = 1'b0;
   logic [127:0] vec_n = '0;
   logic [31:0]  scalar = '0;
   logic [127:0] dst_old = '0;
   logic [15:0]  byte_mask = '0;
   logic [1:0]   elem_size = '0;
   logic         uns_sel = 1'b0;
   logic         sub_sel = 1'b0;
   logic         out_valid;
   logic [127:0] dst_new;
   logic         sat_flag;

   int checks = 0;
   int errors = 0;
   bit exp_flag = 1'b0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   vsat_scalar_unit dut (
      .clk(clk), .rst_n(rst_n), .clr_flag(clr_flag), .in_valid(in_valid),
      .vec_n(vec_n), .scalar(scalar), .dst_old(dst_old), .byte_mask(byte_mask),
      .elem_size(elem_size), .uns_sel(uns_sel), .sub_sel(sub_sel),
      .out_valid(out_valid), .dst_new(dst_new), .sat_flag(sat_flag)
   );

   task automatic check(input bit ok, input string req, input logic [127:0] act,
                        input logic [127:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // Arithmetic reference: exact value, clamp to lane limits, merge by byte.
   function automatic void model(input logic [127:0] n, input logic [31:0] s,
                                 input logic [127:0] old, input logic [15:0] m,
                                 input logic [1:0] sz, input bit uns, input bit sub,
                                 output logic [127:0] res, output bit q);
      res = old;
      q   = 1'b0;
      if (sz == 2'd3) return;
      begin
         int w  = 8 << sz;
         int eb = w / 8;
         longint span = longint'(1) << w;
         for (int e = 0; e < 16 / eb; e++) begin
            logic [127:0] sh = n >> (e * w);
            longint av = longint'(sh[31:0]) & (span - 1);
            longint bv = longint'(s) & (span - 1);
            longint lo = uns ? 0 : -(span / 2);
            longint hi = uns ? span - 1 : span / 2 - 1;
            longint r;
            bit sat = 1'b0;
            if (!uns && av >= span / 2) av -= span;
            if (!uns && bv >= span / 2) bv -= span;
            r = sub ? av - bv : av + bv;
            if (r > hi) begin r = hi; sat = 1'b1; end
            else if (r < lo) begin r = lo; sat = 1'b1; end
            for (int k = 0; k < eb; k++) begin
               int idx = e * eb + k;
               if (m[idx]) res[idx*8 +: 8] = 8'(r >> (8 * k));
            end
            if (sat && m[e*eb]) q = 1'b1;
         end
      end
   endfunction

   // Drive at a falling edge, result checked at the next falling edge.
   task automatic op(input logic [127:0] n, input logic [31:0] s,
                     input logic [127:0] old, input logic [15:0] m,
                     input logic [1:0] sz, input bit uns, input bit sub,
                     input bit clr, input string req);
      logic [127:0] er;
      bit eq;
      model(n, s, old, m, sz, uns, sub, er, eq);
      vec_n = n; scalar = s; dst_old = old; byte_mask = m;
      elem_size = sz; uns_sel = uns; sub_sel = sub; clr_flag = clr;
      in_valid = 1'b1;
      exp_flag = (exp_flag & ~clr) | eq;
      @(negedge clk);
      in_valid = 1'b0;
      clr_flag = 1'b0;
      check(out_valid === 1'b1, {req, " R8 out_valid"}, 128'(out_valid), 128'd1);
      check(dst_new === er, {req, " dst_new"}, dst_new, er);
      check(sat_flag === exp_flag, {req, " R6 flag"}, 128'(sat_flag), 128'(exp_flag));
   endtask

   task automatic clear_flag();
      clr_flag = 1'b1;
      @(negedge clk);
      clr_flag = 1'b0;
      exp_flag = 1'b0;
      check(sat_flag === 1'b0, "R7 clear", 128'(sat_flag), 128'd0);
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog expired actual=running expected=done");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      logic [127:0] v;
      repeat (3) @(negedge clk);
      // R10 reset state
      check(out_valid === 1'b0, "R10 out_valid", 128'(out_valid), 128'd0);
      check(dst_new === '0, "R10 dst_new", dst_new, 128'd0);
      check(sat_flag === 1'b0, "R10 sat_flag", 128'(sat_flag), 128'd0);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 R3 R4: exhaustive byte lanes, every lane value against every scalar
      for (int md = 0; md < 4; md++) begin
         for (int s = 0; s < 256; s++) begin
            for (int blk = 0; blk < 16; blk++) begin
               for (int i = 0; i < 16; i++) v[i*8 +: 8] = 8'(blk * 16 + i);
               op(v, {24'h5A5A5A, 8'(s)}, ~v, 16'hFFFF, 2'd0, md[0], md[1],
                  1'b0, "R1 R3 R4 byte sweep");
            end
         end
         clear_flag();
      end

      // R2 R5: halfword and word lanes with random data, masks and junk upper scalar bits
      for (int t = 0; t < 3000; t++) begin
         logic [127:0] nv = {$urandom, $urandom, $urandom, $urandom};
         logic [127:0] ov = {$urandom, $urandom, $urandom, $urandom};
         logic [31:0]  sv = $urandom;
         logic [1:0]   sz = (t % 2 == 0) ? 2'd1 : 2'd2;
         case (t % 7)
            0: sv = 32'h7FFF_7FFF;
            1: sv = 32'h8000_8000;
            2: sv = 32'hFFFF_FFFF;
            default: ;
         endcase
         op(nv, sv, ov, 16'($urandom), sz, 1'($urandom), 1'($urandom),
            (t % 50) == 0, "R2 R5 wide lanes");
      end
      clear_flag();

      // R6: halfword lane 0 clamps, lowest-byte mask bit 0, upper byte bit 1
      op(128'h7FF0, 32'h0000_0100, '1, 16'h0002, 2'd1, 1'b0, 1'b0, 1'b0,
         "R6 unqualified clamp");
      check(dst_new[15:8] === 8'h7F, "R6 upper byte written", 128'(dst_new[15:8]), 128'h7F);
      check(sat_flag === 1'b0, "R6 flag stays clear", 128'(sat_flag), 128'd0);
      // R6: same clamp with lowest-byte bit set sets the flag
      op(128'h7FF0, 32'h0000_0100, '1, 16'h0001, 2'd1, 1'b0, 1'b0, 1'b0,
         "R6 qualified clamp");
      check(sat_flag === 1'b1, "R6 flag set", 128'(sat_flag), 128'd1);

      // R7: clear with a simultaneous qualifying clamp leaves flag set
      op(128'h7F, 32'h1, '0, 16'hFFFF, 2'd0, 1'b0, 1'b0, 1'b1, "R7 clear+set");
      check(sat_flag === 1'b1, "R7 set wins", 128'(sat_flag), 128'd1);
      // R7: clear with unqualified clamp clears
      op(128'h7FF0, 32'h0000_0100, '1, 16'h0002, 2'd1, 1'b0, 1'b0, 1'b1,
         "R7 clear+unqualified");
      check(sat_flag === 1'b0, "R7 cleared", 128'(sat_flag), 128'd0);
      // R7: non-saturating op keeps flag set
      op(128'h7F, 32'h1, '0, 16'hFFFF, 2'd0, 1'b0, 1'b0, 1'b0, "R7 set again");
      op(128'h01, 32'h1, '0, 16'hFFFF, 2'd0, 1'b0, 1'b0, 1'b0, "R7 sticky");
      check(sat_flag === 1'b1, "R7 sticky hold", 128'(sat_flag), 128'd1);

      // R9: illegal size is a no-op
      clear_flag();
      op(128'h7F7F, 32'h7F, 128'hDEAD_BEEF, 16'hFFFF, 2'd3, 1'b0, 1'b0, 1'b0,
         "R9 illegal size");
      check(dst_new === 128'hDEAD_BEEF, "R9 dst unchanged", dst_new, 128'hDEAD_BEEF);
      check(sat_flag === 1'b0, "R9 flag unchanged", 128'(sat_flag), 128'd0);

      // R8: idle cycles hold the result and drop out_valid
      vec_n = '1; dst_old = '0; byte_mask = '1;
      repeat (3) @(negedge clk);
      check(out_valid === 1'b0, "R8 idle out_valid", 128'(out_valid), 128'd0);
      check(dst_new === 128'hDEAD_BEEF, "R8 idle hold", dst_new, 128'hDEAD_BEEF);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule